// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading translation entries from memory, one level of a radix tree at a time. A requester hands over the virtual address together with the physical base of the root table. The walker then reads one 64-bit entry per level through a simple read port. It ends with a physical address, a page-size code and the leaf's no-execute bit, or with a fault that names the level where the walk stopped.

Each table is 4 KB and holds 512 eight-byte entries, so every level consumes 9 virtual address bits above the 12-bit page offset. The entry at the second level from the top can map a whole 1 GB page, and the entry one level lower can map a 2 MB page. In either case the walk finishes early and no lower table is read. An entry whose present bit is clear stops the walk at once.

Only one memory read is in flight at a time. The block accepts a new request only when idle and holds its result until the requester takes it.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: req_ready is 1, and mem_req_valid and rsp_valid are 0.
- R2: The read at level L (4 = top, 1 = last) targets the table base plus 8 times the 9-bit index vaddr[12+9*(L-1)+8 : 12+9*(L-1)]. The first base is req_root with bits 11:0 ignored, and each later base is bits 51:12 of the previous entry. Every read address is 8-byte aligned.
- R3: A present level-1 entry is a 4 KB leaf. The result is paddr = {entry[51:12], vaddr[11:0]} with rsp_size = 0, after exactly four reads.
- R4: A present level-3 entry with bit 7 set is a 1 GB leaf. The result is paddr = {entry[51:30], vaddr[29:0]} with rsp_size = 2, entry bits 29:12 are ignored, and no further read is issued.
- R5: A present level-2 entry with bit 7 set is a 2 MB leaf. The result is paddr = {entry[51:21], vaddr[20:0]} with rsp_size = 1, and no further read is issued.
- R6: Bit 7 has no effect in a level-4 entry, where the walk continues, or in a level-1 entry, which stays a 4 KB leaf.
- R7: An entry with bit 0 clear at level L ends the walk with rsp_fault = 1 and rsp_level = L, whatever its other bits. No further read is issued, and rsp_paddr and rsp_nx read 0.
- R8: rsp_nx equals bit 63 of the leaf entry. Bit 63 of non-leaf entries has no effect on it.
- R9: mem_req_valid with its address is held stable until mem_req_ready. After the handshake no new read is issued until the response arrives.
- R10: req_ready is 1 only while idle. rsp_valid and the result fields hold stable until rsp_ready, after which the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root | input | 52 | Physical base of the top-level table (bits 11:0 ignored) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_level | output | 3 | Level (4..1) of the faulting entry, 0 when no fault |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_size | output | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_nx | output | 1 | No-execute bit of the leaf |

## Verification
A wrong level counter or table base shows up at the very next read address. That address is compared on every read, so a corrupted index or base is visible within one cycle of mem_req_valid rising. A wrong leaf decision shows up as an extra or missing read, or as a wrong size code, and is caught when rsp_valid rises or a read appears where none is expected. A broken offset merge shows up only in rsp_paddr, so the sweep uses all-ones and alternating-bit virtual addresses at every page size, with frame bases whose low bits are deliberately non-zero.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_DONE  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/pw_index.sv
// Selects the 9-bit index of the current level and forms the entry address.
module pw_index #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int ENT_LG = 3
) (
    input  logic [VA_W-1:OFF_W]          vpn,
    input  logic [PA_W-1:OFF_W]          frame,
    input  logic [$clog2(LEVELS)-1:0]    lvl,
    output logic [PA_W-1:0]              entry_addr
);
    localparam int LVL_W = $clog2(LEVELS);

    logic [IDX_W-1:0] idx_tab [LEVELS];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_tab[g] = vpn[OFF_W + g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) idx = idx_tab[i];
        end
    end

    assign entry_addr = {frame, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_LG);
endmodule

// File: rtl/pw_leaf.sv
// Decodes one entry: present, leaf, next table frame, leaf address merge.
module pw_leaf #(
    parameter int PA_W      = 52,
    parameter int ENT_W     = 64,
    parameter int LEVELS    = 4,
    parameter int IDX_W     = 9,
    parameter int OFF_W     = 12,
    parameter int LARGE_MAX = 2,
    parameter int LARGE_BIT = 7,
    parameter int NX_BIT    = 63
) (
    input  logic [ENT_W-1:0]                     entry,
    input  logic [$clog2(LEVELS)-1:0]            lvl,
    input  logic [OFF_W+LARGE_MAX*IDX_W-1:0]     voff,
    output logic                                 present,
    output logic                                 leaf,
    output logic [PA_W-1:OFF_W]                  next_frame,
    output logic [PA_W-1:0]                      paddr,
    output logic                                 nx
);
    localparam int LVL_W = $clog2(LEVELS);

    logic [PA_W-1:0] pa_tab [LARGE_MAX+1];
    logic            unused_bits;

    for (genvar g = 0; g <= LARGE_MAX; g++) begin : g_pa
        localparam int SPLIT = OFF_W + g*IDX_W;
        assign pa_tab[g] = {entry[PA_W-1:SPLIT], voff[SPLIT-1:0]};
    end

    assign present    = entry[0];
    assign next_frame = entry[PA_W-1:OFF_W];
    assign nx         = entry[NX_BIT];
    assign leaf       = (lvl == '0) ||
                        (entry[LARGE_BIT] && (int'(lvl) <= LARGE_MAX));

    always_comb begin
        paddr = pa_tab[0];
        for (int i = 1; i <= LARGE_MAX; i++) begin
            if (lvl == LVL_W'(i)) paddr = pa_tab[i];
        end
    end

    assign unused_bits = ^{entry[NX_BIT-1:PA_W], entry[OFF_W-1:LARGE_BIT+1],
                           entry[LARGE_BIT-1:1]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 48,
    parameter int PA_W      = 52,
    parameter int ENT_W     = 64,
    parameter int LEVELS    = 4,
    parameter int IDX_W     = 9,
    parameter int OFF_W     = 12,
    parameter int LARGE_MAX = 2,
    parameter int LARGE_BIT = 7,
    parameter int NX_BIT    = 63
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [PA_W-1:0]               req_root,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [PA_W-1:0]               mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [ENT_W-1:0]              mem_rsp_data,
    output logic                          rsp_valid,
    input  logic                          rsp_ready,
    output logic                          rsp_fault,
    output logic [$clog2(LEVELS):0]       rsp_level,
    output logic [PA_W-1:0]               rsp_paddr,
    output logic [$clog2(LEVELS)-1:0]     rsp_size,
    output logic                          rsp_nx
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int VOFF_W = OFF_W + LARGE_MAX*IDX_W;

    typedef struct packed {
        walk_st_e              st;
        logic [LVL_W-1:0]      lvl;
        logic [VA_W-1:0]       va;
        logic [PA_W-1:OFF_W]   frame;
        logic                  fault;
        logic [LVL_W:0]        flvl;
        logic [PA_W-1:0]       pa;
        logic [LVL_W-1:0]      size;
        logic                  nx;
    } walk_t;

    walk_t d, q;

    logic                ent_present, ent_leaf, ent_nx;
    logic [PA_W-1:OFF_W] ent_next;
    logic [PA_W-1:0]     ent_pa;
    logic                unused_root;

    assign unused_root = ^req_root[OFF_W-1:0];

    pw_index #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS),
        .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_LG(3)
    ) u_index (
        .vpn        (q.va[VA_W-1:OFF_W]),
        .frame      (q.frame),
        .lvl        (q.lvl),
        .entry_addr (mem_req_addr)
    );

    pw_leaf #(
        .PA_W(PA_W), .ENT_W(ENT_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
        .OFF_W(OFF_W), .LARGE_MAX(LARGE_MAX), .LARGE_BIT(LARGE_BIT),
        .NX_BIT(NX_BIT)
    ) u_leaf (
        .entry      (mem_rsp_data),
        .lvl        (q.lvl),
        .voff       (q.va[VOFF_W-1:0]),
        .present    (ent_present),
        .leaf       (ent_leaf),
        .next_frame (ent_next),
        .paddr      (ent_pa),
        .nx         (ent_nx)
    );

    always_comb begin
        d             = q;
        req_ready     = (q.st == W_IDLE);
        mem_req_valid = (q.st == W_ISSUE);
        rsp_valid     = (q.st == W_DONE);
        case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    d.st    = W_ISSUE;
                    d.lvl   = LVL_W'(LEVELS-1);
                    d.va    = req_vaddr;
                    d.frame = req_root[PA_W-1:OFF_W];
                    d.fault = 1'b0;
                    d.flvl  = '0;
                    d.pa    = '0;
                    d.size  = '0;
                    d.nx    = 1'b0;
                end
            end
            W_ISSUE: begin
                if (mem_req_ready) d.st = W_WAIT;
            end
            W_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        d.st    = W_DONE;
                        d.fault = 1'b1;
                        d.flvl  = (LVL_W+1)'(q.lvl) + 1'b1;
                    end else if (ent_leaf) begin
                        d.st   = W_DONE;
                        d.pa   = ent_pa;
                        d.size = q.lvl;
                        d.nx   = ent_nx;
                    end else begin
                        d.st    = W_ISSUE;
                        d.frame = ent_next;
                        d.lvl   = q.lvl - 1'b1;
                    end
                end
            end
            W_DONE: begin
                if (rsp_ready) d.st = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_fault = q.fault;
    assign rsp_level = q.flvl;
    assign rsp_paddr = q.pa;
    assign rsp_size  = q.size;
    assign rsp_nx    = q.nx;

    // R9: read request held with a stable address until accepted
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R9: no back-to-back read after a handshake (response must come first)
    p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R10: result held until taken
    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid &&
        $stable({rsp_fault, rsp_level, rsp_paddr, rsp_size, rsp_nx}));

    // R10: accepting requests only while nothing else is in progress
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !rsp_valid);

    // R2: entry addresses are 8-byte aligned
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    // R4: a 1 GB result keeps the low 30 virtual bits
    p_gb_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && rsp_size == LVL_W'(2) |->
        rsp_paddr[OFF_W+2*IDX_W-1:0] == q.va[OFF_W+2*IDX_W-1:0]);

    // R7: a fault carries a level and no translation
    p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_level != '0 && rsp_paddr == '0 && !rsp_nx);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [51:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [2:0]  rsp_level;
    logic [51:0] rsp_paddr;
    logic [1:0]  rsp_size;
    logic        rsp_nx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [51:0] LEAF_FR = 52'h9_8765_4321_5000;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level),
        .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_nx(rsp_nx)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [51:0] next_base(int lvl);
        return 52'h0_00C3_5000_0000 + 52'(lvl) * 52'h1_7000;
    endfunction

    task automatic wait_mem_req();
        int t = 0;
        while (!mem_req_valid && t < 40) begin
            @(negedge clk);
            t++;
        end
    endtask

    // One walk: levels 4 down to term_l are read; term_l either faults or is a leaf.
    task automatic walk(logic [47:0] va, logic [51:0] root, int term_l,
                        bit is_fault, bit nx, bit ign7, bit stall);
        logic [51:0] base;
        logic [51:0] exp_addr;
        logic [51:0] exp_pa;
        logic [63:0] e;
        logic [51:0] held_pa;
        string       tag;
        @(negedge clk);
        check("R10", "req_ready idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "req_ready busy", 64'(req_ready), 64'd0);
        base = {root[51:12], 12'h000};
        for (int lv = 4; lv >= term_l; lv--) begin
            wait_mem_req();
            exp_addr = base + 52'(va[12 + 9*(lv-1) +: 9]) * 52'd8;
            check("R2", $sformatf("read addr level %0d", lv), 64'(mem_req_addr), 64'(exp_addr));
            if (stall) begin
                @(negedge clk);
                check("R9", "held request", {11'd0, mem_req_valid, mem_req_addr},
                      {11'd0, 1'b1, exp_addr});
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            check("R9", "no read before response", 64'(mem_req_valid), 64'd0);
            if (lv == term_l && is_fault) begin
                e = 64'hFFFF_FFFF_FFFF_FFFE;
            end else if (lv == term_l) begin
                e = '0;
                e[0] = 1'b1;
                e[7] = (lv == 1) ? ign7 : 1'b1;
                e[51:12] = LEAF_FR[51:12];
                e[63] = nx;
            end else begin
                e = '0;
                e[0] = 1'b1;
                e[7] = (lv == 4) ? ign7 : 1'b0;
                e[51:12] = next_base(lv) >> 12;
                e[63] = ~nx;
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = e;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            base = next_base(lv);
        end
        if (is_fault) tag = "R7";
        else if (term_l == 3) tag = "R4";
        else if (term_l == 2) tag = "R5";
        else if (ign7) tag = "R6";
        else tag = "R3";
        check(tag, "result ready, no extra read", {62'd0, rsp_valid, mem_req_valid}, 64'b10);
        case (term_l)
            1: exp_pa = {LEAF_FR[51:12], va[11:0]};
            2: exp_pa = {LEAF_FR[51:21], va[20:0]};
            default: exp_pa = {LEAF_FR[51:30], va[29:0]};
        endcase
        if (is_fault) begin
            check("R7", "fault flag", 64'(rsp_fault), 64'd1);
            check("R7", "fault level", 64'(rsp_level), 64'(term_l));
            check("R7", "fault paddr", 64'(rsp_paddr), 64'd0);
            check("R7", "fault nx", 64'(rsp_nx), 64'd0);
        end else begin
            check(tag, "no fault", {61'd0, rsp_fault, rsp_level[1:0]}, 64'd0);
            check(tag, "paddr", 64'(rsp_paddr), 64'(exp_pa));
            check(tag, "size", 64'(rsp_size), 64'(term_l - 1));
            check("R8", "nx from leaf", 64'(rsp_nx), 64'(nx));
            if (ign7 && term_l != 4) check("R6", "level-4 bit7 ignored", 64'(rsp_size), 64'(term_l - 1));
        end
        held_pa = rsp_paddr;
        @(negedge clk);
        check("R10", "result held", {11'd0, rsp_valid, rsp_paddr}, {11'd0, 1'b1, held_pa});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R10", "idle after take", {62'd0, req_ready, rsp_valid}, 64'b10);
    endtask

    initial begin
        logic [47:0] vas [4];
        logic [51:0] roots [2];
        int          k;
        vas[0] = 48'h0000_0000_0000;
        vas[1] = 48'hFFFF_FFFF_FFFF;
        vas[2] = 48'h5A5A_C3C3_9696;
        vas[3] = 48'h1234_5678_9ABC;
        roots[0] = 52'hF_0000_0012_3FFF;
        roots[1] = 52'h0_0ABC_D000_0000;
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {61'd0, req_ready, mem_req_valid, rsp_valid}, 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", {61'd0, req_ready, mem_req_valid, rsp_valid}, 64'b100);
        k = 0;
        for (int v = 0; v < 4; v++) begin
            for (int lv = 1; lv <= 4; lv++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int x = 0; x < 2; x++) begin
                        for (int g7 = 0; g7 < 2; g7++) begin
                            if (f == 0 && lv == 4) continue;
                            walk(vas[v], roots[k % 2], lv, f == 1, x == 1, g7 == 1, (k % 3) == 1);
                            k++;
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule